// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is the one-shot countdown timer of a per-core interrupt controller. Software programs it through a plain 32-bit register port with an address, a write strobe, write data and a read strobe. Four registers are implemented: a timer entry that holds the interrupt vector and a mask bit, a start-count register, a read-only live count, and a divider select. All other offsets are rejected with an error pulse.

Writing the start-count register loads the countdown and starts it. A prescaler, reset by that write, divides the core clock by a power of two. The ratio is chosen by a scrambled 3-bit code and is captured at the same write. When the count reaches zero it stays there. The block then emits a single-cycle interrupt request and presents the programmed vector beside it, unless the entry is masked. The register port has no back-pressure: every access completes in one cycle and has no handshake. Read data and the error flag follow one cycle after the strobe.

Top module: `cdt_timer`

## Requirements
- R1: Registers decode on address bits 11:3, with bits 2:0 ignored. The timer entry is at 0x320, the start count at 0x380, the live count at 0x390 and the divider select at 0x3E0.
- R2: A read or write at any other offset raises `bus_err` for one cycle. A read there returns zero, and a write there changes no register.
- R3: After reset the timer entry reads 0x00010000 (mask bit 16 set). The start count, live count and divider select read zero, and `irq_pulse` is low.
- R4: The divider select stores only bits 3, 1 and 0 of a write (mask 0xB). Its other bits read as zero.
- R5: The divider code is {select[3], select[1:0]}. The decrement period is 2^((code+1) mod 8) clocks, so code 0 gives 2 and code 7 gives 1.
- R6: A write to the start count stores all 32 bits, which read back unchanged. It reloads the live count with that value and restarts the prescaler, even while a countdown is running.
- R7: The divider ratio in force at the start-count write governs the whole countdown. Later writes to the divider select do not change it.
- R8: The live count is read-only, and writes to it are ignored. A read returns the value held in the cycle of the read strobe, which decreases by one every period.
- R9: Start count N written at clock edge E with period D makes `irq_pulse` high for exactly one cycle, after edge E+N·D. The live count is then zero and stays zero. `irq_vector` carries timer entry bits 7:0.
- R10: Writing a start count of zero stops the countdown at zero and raises no interrupt.
- R11: While timer entry bit 16 is set, expiry raises no interrupt. The count still runs down to zero.
- R12: Timer entry bits 12 and 14 are read-only and keep their value (zero) on writes. All other bits take the written value.
- R13: `bus_rdata` and `bus_err` update at the clock edge that samples the strobe. `bus_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Undefined-offset pulse, registered |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
Read data and the error flag are due one edge after the strobe, so each access task drives at a falling edge and samples at the next falling edge. The expiry request is due N·D edges after the edge that takes the start-count write. The bench counts falling edges from that write and requires the first high sample at exactly N·D and no second one. For live-count reads it works out which decrement edges have passed before the capturing edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int OFF_ENTRY = 'h320;
  localparam int OFF_START = 'h380;
  localparam int OFF_LIVE  = 'h390;
  localparam int OFF_DSEL  = 'h3E0;

  localparam int SHIFT_W     = 3;
  localparam int MASK_BIT    = 16;
  localparam int RO_BIT_A    = 12;
  localparam int RO_BIT_B    = 14;
  localparam logic [31:0] DSEL_KEEP = 32'h0000_000B;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENTRY,
    SEL_START,
    SEL_LIVE,
    SEL_DSEL
  } reg_sel_e;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] live_cnt,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [DATA_W-1:0] entry_q,
  output logic              load,
  output logic [DATA_W-1:0] load_val,
  output logic [SHIFT_W-1:0] shift_sel
);
  localparam int WORD_W = ADDR_W - 3;
  localparam logic [WORD_W-1:0] W_ENTRY = WORD_W'(OFF_ENTRY >> 3);
  localparam logic [WORD_W-1:0] W_START = WORD_W'(OFF_START >> 3);
  localparam logic [WORD_W-1:0] W_LIVE  = WORD_W'(OFF_LIVE >> 3);
  localparam logic [WORD_W-1:0] W_DSEL  = WORD_W'(OFF_DSEL >> 3);
  localparam logic [DATA_W-1:0] RO_MASK =
    (DATA_W'(1) << RO_BIT_A) | (DATA_W'(1) << RO_BIT_B);
  localparam logic [DATA_W-1:0] ENTRY_RST = DATA_W'(1) << MASK_BIT;
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(DSEL_KEEP);

  logic [WORD_W-1:0] word;
  logic [2:0]        unused_byte;
  reg_sel_e          sel;
  logic [DATA_W-1:0] start_q, dsel_q, rmux;
  logic [SHIFT_W-1:0] code;

  assign word        = bus_addr[ADDR_W-1:3];
  assign unused_byte = bus_addr[2:0];

  always_comb begin
    if      (word == W_ENTRY) sel = SEL_ENTRY;
    else if (word == W_START) sel = SEL_START;
    else if (word == W_LIVE)  sel = SEL_LIVE;
    else if (word == W_DSEL)  sel = SEL_DSEL;
    else                      sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_ENTRY: rmux = entry_q;
      SEL_START: rmux = start_q;
      SEL_LIVE:  rmux = live_cnt;
      SEL_DSEL:  rmux = dsel_q;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= ENTRY_RST;
      start_q <= '0;
      dsel_q  <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_ENTRY: entry_q <= (bus_wdata & ~RO_MASK) | (entry_q & RO_MASK);
        SEL_START: start_q <= bus_wdata;
        SEL_DSEL:  dsel_q  <= bus_wdata & KEEP;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= (bus_rd || bus_wr) && (sel == SEL_NONE);
      if (bus_rd) bus_rdata <= rmux;
    end
  end

  assign load      = bus_wr && (sel == SEL_START);
  assign load_val  = bus_wdata;
  assign code      = {dsel_q[3], dsel_q[1:0]};
  assign shift_sel = code + SHIFT_W'(1);
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift_in,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0]   pre;
  logic [SHIFT_W-1:0] shift_q;
  logic [PRE_W:0]     span, lim;

  assign span = (PRE_W+1)'(1) << shift_q;
  assign lim  = span - (PRE_W+1)'(1);
  assign tick = run && !restart && (pre == lim[PRE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      shift_q <= '0;
    end else if (restart) begin
      pre     <= '0;
      shift_q <= shift_in;
    end else if (run) begin
      pre <= tick ? '0 : pre + PRE_W'(1);
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  input  logic              masked,
  output logic [DATA_W-1:0] cnt,
  output logic              run,
  output logic              irq
);
  assign run = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      irq <= 1'b0;
    end else if (tick && run) begin
      cnt <= cnt - DATA_W'(1);
      irq <= (cnt == DATA_W'(1)) && !masked;
    end else begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [DATA_W-1:0]  entry_q, load_val, live_cnt;
  logic               load, tick, run;
  logic [SHIFT_W-1:0] shift_sel;

  cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .live_cnt(live_cnt),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .entry_q(entry_q), .load(load), .load_val(load_val),
    .shift_sel(shift_sel)
  );

  cdt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load), .run(run),
    .shift_in(shift_sel), .tick(tick)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .tick(tick), .masked(entry_q[MASK_BIT]),
    .cnt(live_cnt), .run(run), .irq(irq_pulse)
  );

  assign irq_vector = entry_q[VEC_W-1:0];
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic              load,
  input logic [DATA_W-1:0] load_val,
  input logic [DATA_W-1:0] entry,
  input logic              bus_rd,
  input logic              bus_err,
  input logic [DATA_W-1:0] bus_rdata
);
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0));
  p_zero_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) || cnt == $past(cnt) - DATA_W'(1)));
  p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !entry[16]);
  p_zero_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !irq);
  p_ro_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !entry[12] && !entry[14]);
  p_err_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && $past(bus_rd)) |-> (bus_rdata == '0));
endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_pulse), .cnt(live_cnt),
  .load(load), .load_val(load_val), .entry(entry_q),
  .bus_rd(bus_rd), .bus_err(bus_err), .bus_rdata(bus_rdata)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  localparam int PERIOD = 10;
  localparam logic [11:0] A_ENTRY = 12'h320;
  localparam logic [11:0] A_START = 12'h380;
  localparam logic [11:0] A_LIVE  = 12'h390;
  localparam logic [11:0] A_DSEL  = 12'h3E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int n_cmp = 0;
  int n_bad = 0;

  cdt_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output logic err);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    err = bus_err;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic err);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; err = bus_err;
  endtask

  task automatic wait_irq(input int k0, input int kmax, output int first_k,
                          output int pulses, output logic [7:0] vec);
    first_k = -1; pulses = 0; vec = '0;
    for (int k = k0 + 1; k <= kmax; k++) begin
      @(negedge clk);
      if (irq_pulse) begin
        if (first_k < 0) begin first_k = k; vec = irq_vector; end
        pulses++;
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    check("R3 irq", {31'b0, irq_pulse}, 32'd0);
    bus_read(A_ENTRY, d, e); check("R3 entry", d, 32'h0001_0000);
    check("R13 err on good read", {31'b0, e}, 32'd0);
    bus_read(A_START, d, e); check("R3 start", d, 32'd0);
    bus_read(A_LIVE, d, e);  check("R3 live", d, 32'd0);
    bus_read(A_DSEL, d, e);  check("R3 dsel", d, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d; logic e;
    bus_write(A_DSEL, 32'hFFFF_FFFF, e);
    bus_read(A_DSEL, d, e); check("R4 dsel mask", d, 32'h0000_000B);
    bus_read(12'h3E4, d, e); check("R1 low bits ignored", d, 32'h0000_000B);
    bus_write(A_ENTRY, 32'hFFFF_FFFF, e);
    bus_read(A_ENTRY, d, e); check("R12 ro bits", d, 32'hFFFF_AFFF);
    bus_write(12'h3F0, 32'h1234_5678, e); check("R2 write err", {31'b0, e}, 32'd1);
    bus_read(A_ENTRY, d, e); check("R2 no side effect", d, 32'hFFFF_AFFF);
    bus_read(12'h328, d, e);
    check("R2 read err", {31'b0, e}, 32'd1);
    check("R2 read zero", d, 32'd0);
    bus_read(A_DSEL, d, e); check("R13 rdata after err", d, 32'h0000_000B);
  endtask

  task automatic t_live;
    logic [31:0] d; logic e; int k, p; logic [7:0] v;
    bus_write(A_ENTRY, 32'h0000_0042, e);
    bus_write(A_DSEL, 32'h1, e);               // code 1 -> period 4
    bus_write(A_START, 32'd10, e);             // k=0
    bus_read(A_LIVE, d, e); check("R8 live after load", d, 32'd10);   // k=1
    repeat (8) @(negedge clk);                 // k=9
    bus_read(A_LIVE, d, e); check("R8 live decrements", d, 32'd8);    // captured edge 10
    bus_read(A_START, d, e); check("R6 start readback", d, 32'd10);   // k=11
    wait_irq(11, 45, k, p, v);
    check("R9 expiry cycle", k, 32'd40);
    check("R9 single pulse", p, 32'd1);
    check("R9 vector", {24'b0, v}, 32'h42);
    bus_read(A_LIVE, d, e); check("R9 stays zero", d, 32'd0);
  endtask

  task automatic t_divs;
    logic e; int k, p; logic [7:0] v;
    for (int c = 0; c < 8; c++) begin
      int ratio;
      ratio = (c == 7) ? 1 : (2 << c);
      bus_write(A_DSEL, {28'b0, c[2], 1'b0, c[1:0]}, e);
      bus_write(A_START, 32'd3, e);
      wait_irq(0, 3*ratio + 4, k, p, v);
      check($sformatf("R5 code %0d", c), k, 3*ratio);
      check($sformatf("R5 code %0d pulses", c), p, 1);
    end
  endtask

  task automatic t_latch;
    logic e; int k, p; logic [7:0] v;
    bus_write(A_DSEL, 32'h0, e);               // period 2
    bus_write(A_START, 32'd4, e);              // k=0
    bus_write(A_DSEL, 32'hB, e);               // k=1, period 1 now selected
    wait_irq(1, 14, k, p, v);
    check("R7 ratio latched", k, 32'd8);
  endtask

  task automatic t_restart_and_stop;
    logic [31:0] d; logic e; int k, p; logic [7:0] v;
    bus_write(A_DSEL, 32'hB, e);
    bus_write(A_START, 32'd20, e);
    bus_write(A_START, 32'd5, e);
    wait_irq(0, 30, k, p, v);
    check("R6 restart", k, 32'd5);
    check("R6 restart one pulse", p, 32'd1);
    bus_write(A_START, 32'hFFFF_FFF0, e);
    bus_read(A_START, d, e); check("R6 full width", d, 32'hFFFF_FFF0);
    bus_write(A_START, 32'd0, e);
    wait_irq(0, 20, k, p, v);
    check("R10 zero stops no irq", p, 32'd0);
    bus_read(A_LIVE, d, e); check("R10 live zero", d, 32'd0);
  endtask

  task automatic t_live_ro;
    logic [31:0] d; logic e;
    bus_write(A_DSEL, 32'hA, e);               // code 6 -> period 128
    bus_write(A_START, 32'd100, e);            // k=0
    bus_write(A_LIVE, 32'd5, e);               // k=1
    bus_read(A_LIVE, d, e); check("R8 write ignored", d, 32'd100);
    bus_write(A_START, 32'd0, e);
  endtask

  task automatic t_mask;
    logic [31:0] d; logic e; int k, p; logic [7:0] v;
    bus_write(A_ENTRY, 32'h0001_0042, e);
    bus_write(A_DSEL, 32'hB, e);
    bus_write(A_START, 32'd2, e);
    wait_irq(0, 10, k, p, v);
    check("R11 masked no irq", p, 32'd0);
    bus_read(A_LIVE, d, e); check("R11 count ran out", d, 32'd0);
    bus_write(A_ENTRY, 32'h0000_0042, e);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_live();
    t_divs();
    t_latch();
    t_restart_and_stop();
    t_live_ro();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule